// File: doc/BRIEF.md
# Stack and Next-PC Control Unit

This block is purely combinational control for a 64-bit sequential processor. It takes an instruction that has already been decoded and works out four results. It gives the address of the next instruction. It gives the updated stack pointer. It gives the memory address, write data and access direction for instructions that touch memory or the stack. It gives a three-bit status code.

The stack lives in a byte-addressed data memory of `MEM_BYTES` bytes and grows toward lower addresses, one 8-byte word per entry. Subroutine linkage goes through that stack, and jumps carry absolute targets. Any status other than normal forces every update-enable output low, so the surrounding datapath commits nothing for that instruction. Register-file and memory storage sit outside this block.

Top module: `stk_pc_ctrl`

## Requirements
- R1: Push (icode 0xA) requests a memory write of `srca_i` at `sp_i - 8` and drives `new_sp_o = sp_i - 8` with `sp_we_o` high.
- R2: Pop (icode 0xB) requests a memory read at `sp_i` and drives `new_sp_o = sp_i + 8` with `sp_we_o` high.
- R3: Call (icode 0x8) writes `valp_i` at `sp_i - 8`, lowers the stack pointer by 8, and drives `next_pc_o = valc_i`.
- R4: Return (icode 0x9) reads at `sp_i`, raises the stack pointer by 8, and drives `next_pc_o = rdata_i`.
- R5: A conditional jump (icode 0x7) drives `next_pc_o = valc_i` when `cond_i` is high and `valp_i` otherwise, with no memory access.
- R6: Store (icode 0x4) writes `srca_i` at `base_i + valc_i`. Load (icode 0x5) reads at `base_i + valc_i`. Neither changes the stack pointer.
- R7: Halt (0x0), nop (0x1), register move (0x2), immediate load (0x3) and ALU op (0x6) drive `next_pc_o = valp_i`, make no memory access and leave `sp_we_o` low.
- R8: `stat_o` is 1 (normal), 2 (halted), 3 (bad address) or 4 (invalid instruction). Bad address is raised by `imem_err_i`, or by a data access whose address exceeds `MEM_BYTES - 8` as an unsigned number.
- R9: When several conditions hold at once, bad address wins over invalid instruction, which wins over halt.
- R10: When `stat_o` is not 1, `pc_we_o`, `sp_we_o`, `mem_rd_o` and `mem_wr_o` are all low. When it is 1, `pc_we_o` is high.
- R11: Icodes 0xC to 0xF, or `instr_err_i` high, give invalid instruction and make no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| icode_i | input | 4 | Decoded instruction code |
| cond_i | input | 1 | Branch/move condition is true |
| valc_i | input | 64 | Constant word: target or displacement |
| valp_i | input | 64 | Sequential next-instruction address |
| sp_i | input | 64 | Current stack pointer |
| base_i | input | 64 | Base register value for store/load |
| srca_i | input | 64 | Source register value to store |
| rdata_i | input | 64 | Word read from data memory |
| instr_err_i | input | 1 | Decoder flags invalid instruction |
| imem_err_i | input | 1 | Instruction fetch hit a bad address |
| next_pc_o | output | 64 | Next program counter |
| pc_we_o | output | 1 | Commit next_pc_o |
| new_sp_o | output | 64 | Updated stack pointer |
| sp_we_o | output | 1 | Commit new_sp_o |
| mem_addr_o | output | 64 | Data memory byte address |
| mem_wdata_o | output | 64 | Data memory write word |
| mem_rd_o | output | 1 | Data memory read request |
| mem_wr_o | output | 1 | Data memory write request |
| stat_o | output | 3 | Status code |

## Verification
The block holds no state, so a wrong selection shows at the ports in the same evaluation as the input change that exposes it. A wrong stack-adjust direction or offset shows up as a `new_sp_o` or `mem_addr_o` that is off by 8 or 16 for push, pop, call or return. A wrong status priority shows up as a write-enable that stays high on a faulting access, or as the wrong code when two errors coincide. Boundary addresses just inside and just outside the memory, including wrap below zero, are what expose an off-by-one in the range check.

// File: rtl/stk_pc_pkg.sv
package stk_pc_pkg;
  typedef enum logic [3:0] {
    IC_HALT  = 4'h0,
    IC_NOP   = 4'h1,
    IC_CMOV  = 4'h2,
    IC_IRMOV = 4'h3,
    IC_STORE = 4'h4,
    IC_LOAD  = 4'h5,
    IC_ALU   = 4'h6,
    IC_JUMP  = 4'h7,
    IC_CALL  = 4'h8,
    IC_RET   = 4'h9,
    IC_PUSH  = 4'hA,
    IC_POP   = 4'hB
  } icode_e;

  typedef enum logic [2:0] {
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } stat_e;
endpackage

// File: rtl/stk_pc_next.sv
module stk_pc_next
  import stk_pc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   icode_i,
  input  logic         cond_i,
  input  logic [W-1:0] valc_i,
  input  logic [W-1:0] valp_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] next_pc_o
);
  always_comb begin
    case (icode_i)
      IC_JUMP: next_pc_o = cond_i ? valc_i : valp_i;
      IC_CALL: next_pc_o = valc_i;
      IC_RET:  next_pc_o = rdata_i;
      default: next_pc_o = valp_i;
    endcase
  end
endmodule

// File: rtl/stk_pc_mem.sv
module stk_pc_mem
  import stk_pc_pkg::*;
#(
  parameter int W         = 64,
  parameter int MEM_BYTES = 4096
) (
  input  logic [3:0]   icode_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] valc_i,
  input  logic [W-1:0] valp_i,
  input  logic [W-1:0] srca_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wdata_o,
  output logic         rd_o,
  output logic         wr_o,
  output logic [W-1:0] new_sp_o,
  output logic         sp_chg_o,
  output logic         bad_o
);
  localparam int          STEP      = 8;
  localparam logic [W-1:0] STEP_W   = W'(STEP);
  localparam logic [W-1:0] LAST_OK  = W'(MEM_BYTES - STEP);

  logic [W-1:0] sp_dn, sp_up;
  assign sp_dn = sp_i - STEP_W;
  assign sp_up = sp_i + STEP_W;

  always_comb begin
    addr_o   = '0;
    wdata_o  = '0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    new_sp_o = sp_i;
    sp_chg_o = 1'b0;
    case (icode_i)
      IC_STORE: begin
        addr_o  = base_i + valc_i;
        wdata_o = srca_i;
        wr_o    = 1'b1;
      end
      IC_LOAD: begin
        addr_o = base_i + valc_i;
        rd_o   = 1'b1;
      end
      IC_PUSH, IC_CALL: begin
        addr_o   = sp_dn;
        wdata_o  = (icode_i == IC_CALL) ? valp_i : srca_i;
        wr_o     = 1'b1;
        new_sp_o = sp_dn;
        sp_chg_o = 1'b1;
      end
      IC_POP, IC_RET: begin
        addr_o   = sp_i;
        rd_o     = 1'b1;
        new_sp_o = sp_up;
        sp_chg_o = 1'b1;
      end
      default: ;
    endcase
  end

  // unsigned compare also catches wrap below zero
  assign bad_o = (rd_o | wr_o) & (addr_o > LAST_OK);
endmodule

// File: rtl/stk_pc_stat.sv
module stk_pc_stat
  import stk_pc_pkg::*;
(
  input  logic [3:0] icode_i,
  input  logic       instr_err_i,
  input  logic       imem_err_i,
  input  logic       dmem_bad_i,
  output logic [2:0] stat_o,
  output logic       ok_o
);
  logic valid;
  assign valid = (icode_i <= IC_POP) & ~instr_err_i;

  always_comb begin
    if (imem_err_i | dmem_bad_i)  stat_o = ST_ADR;
    else if (!valid)              stat_o = ST_INS;
    else if (icode_i == IC_HALT)  stat_o = ST_HLT;
    else                          stat_o = ST_AOK;
  end

  assign ok_o = (stat_o == ST_AOK);
endmodule

// File: rtl/stk_pc_ctrl.sv
module stk_pc_ctrl
  import stk_pc_pkg::*;
#(
  parameter int W         = 64,
  parameter int MEM_BYTES = 4096
) (
  input  logic [3:0]   icode_i,
  input  logic         cond_i,
  input  logic [W-1:0] valc_i,
  input  logic [W-1:0] valp_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] srca_i,
  input  logic [W-1:0] rdata_i,
  input  logic         instr_err_i,
  input  logic         imem_err_i,
  output logic [W-1:0] next_pc_o,
  output logic         pc_we_o,
  output logic [W-1:0] new_sp_o,
  output logic         sp_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         mem_rd_o,
  output logic         mem_wr_o,
  output logic [2:0]   stat_o
);
  logic rd_req, wr_req, sp_chg, dmem_bad, ok;

  stk_pc_next #(.W(W)) u_next (
    .icode_i  (icode_i),
    .cond_i   (cond_i),
    .valc_i   (valc_i),
    .valp_i   (valp_i),
    .rdata_i  (rdata_i),
    .next_pc_o(next_pc_o)
  );

  stk_pc_mem #(.W(W), .MEM_BYTES(MEM_BYTES)) u_mem (
    .icode_i (icode_i),
    .sp_i    (sp_i),
    .base_i  (base_i),
    .valc_i  (valc_i),
    .valp_i  (valp_i),
    .srca_i  (srca_i),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .rd_o    (rd_req),
    .wr_o    (wr_req),
    .new_sp_o(new_sp_o),
    .sp_chg_o(sp_chg),
    .bad_o   (dmem_bad)
  );

  stk_pc_stat u_stat (
    .icode_i    (icode_i),
    .instr_err_i(instr_err_i),
    .imem_err_i (imem_err_i),
    .dmem_bad_i (dmem_bad),
    .stat_o     (stat_o),
    .ok_o       (ok)
  );

  assign pc_we_o  = ok;
  assign sp_we_o  = ok & sp_chg;
  assign mem_rd_o = ok & rd_req;
  assign mem_wr_o = ok & wr_req;
endmodule

// File: rtl/stk_pc_ctrl_chk.sv
module stk_pc_ctrl_chk #(
  parameter int W         = 64,
  parameter int MEM_BYTES = 4096
) (
  input logic [3:0]   icode_i,
  input logic         imem_err_i,
  input logic [W-1:0] sp_i,
  input logic [W-1:0] rdata_i,
  input logic [W-1:0] next_pc_o,
  input logic         pc_we_o,
  input logic [W-1:0] new_sp_o,
  input logic         sp_we_o,
  input logic [W-1:0] mem_addr_o,
  input logic         mem_rd_o,
  input logic         mem_wr_o,
  input logic [2:0]   stat_o
);
  localparam logic [W-1:0] LAST_OK = W'(MEM_BYTES - 8);

  always_comb begin
    a_r10_gate_off: assert (stat_o == 3'd1 || !(pc_we_o || sp_we_o || mem_rd_o || mem_wr_o))
      else $error("enable high with status %0d", stat_o);
    a_r8_addr_in_range: assert (!(mem_rd_o || mem_wr_o) || mem_addr_o <= LAST_OK)
      else $error("access out of range");
    a_r1_push_predec: assert (!(icode_i == 4'hA && sp_we_o) ||
                              (new_sp_o == sp_i - W'(8) && mem_addr_o == new_sp_o))
      else $error("push stack update wrong");
    a_r4_ret_target: assert (!(icode_i == 4'h9 && pc_we_o) || next_pc_o == rdata_i)
      else $error("return target wrong");
    a_r9_adr_first: assert (!imem_err_i || stat_o == 3'd3)
      else $error("fetch error not reported");
    a_r11_no_access: assert (!(icode_i > 4'hB) || (!mem_rd_o && !mem_wr_o))
      else $error("invalid icode accessed memory");
  end
endmodule

bind stk_pc_ctrl stk_pc_ctrl_chk #(.W(W), .MEM_BYTES(MEM_BYTES)) u_chk (
  .icode_i   (icode_i),
  .imem_err_i(imem_err_i),
  .sp_i      (sp_i),
  .rdata_i   (rdata_i),
  .next_pc_o (next_pc_o),
  .pc_we_o   (pc_we_o),
  .new_sp_o  (new_sp_o),
  .sp_we_o   (sp_we_o),
  .mem_addr_o(mem_addr_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .stat_o    (stat_o)
);

// File: tb/stk_pc_ctrl_tb_top.sv
module stk_pc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM = 256;
  localparam logic [63:0] VALC = 64'h0000_0000_0000_1230;
  localparam logic [63:0] VALP = 64'h0000_0000_0000_0456;
  localparam logic [63:0] SRCA = 64'hDEAD_BEEF_0000_0011;
  localparam logic [63:0] RDAT = 64'h0000_0000_0000_0777;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  icode;
  logic        cond, ierr, merr;
  logic [63:0] valc, valp, sp, base, srca, rdata;
  logic [63:0] next_pc, new_sp, maddr, mwdata;
  logic        pc_we, sp_we, mrd, mwr;
  logic [2:0]  stat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  stk_pc_ctrl #(.W(64), .MEM_BYTES(MEM)) dut_i (
    .icode_i(icode), .cond_i(cond), .valc_i(valc), .valp_i(valp),
    .sp_i(sp), .base_i(base), .srca_i(srca), .rdata_i(rdata),
    .instr_err_i(ierr), .imem_err_i(merr),
    .next_pc_o(next_pc), .pc_we_o(pc_we), .new_sp_o(new_sp), .sp_we_o(sp_we),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .stat_o(stat)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s icode=%h act=%h exp=%h", tag, icode, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] ic);
    case (ic)
      4'hA: return "R1";
      4'hB: return "R2";
      4'h8: return "R3";
      4'h9: return "R4";
      4'h7: return "R5";
      4'h4, 4'h5: return "R6";
      4'hC, 4'hD, 4'hE, 4'hF: return "R11";
      default: return "R7";
    endcase
  endfunction

  task automatic run_one();
    logic [63:0] e_pc, e_sp, e_addr, e_wd;
    logic e_rd, e_wr, e_spc, bad, ok;
    logic [2:0] e_st;
    int nerr;
    e_pc = VALP; e_sp = sp; e_addr = 0; e_wd = 0;
    e_rd = 0; e_wr = 0; e_spc = 0;
    case (icode)
      4'h4: begin e_addr = base + valc; e_wd = srca; e_wr = 1; end
      4'h5: begin e_addr = base + valc; e_rd = 1; end
      4'h7: e_pc = cond ? valc : valp;
      4'h8: begin e_addr = sp - 8; e_wd = valp; e_wr = 1; e_sp = sp - 8; e_spc = 1; e_pc = valc; end
      4'h9: begin e_addr = sp; e_rd = 1; e_sp = sp + 8; e_spc = 1; e_pc = rdata; end
      4'hA: begin e_addr = sp - 8; e_wd = srca; e_wr = 1; e_sp = sp - 8; e_spc = 1; end
      4'hB: begin e_addr = sp; e_rd = 1; e_sp = sp + 8; e_spc = 1; end
      default: ;
    endcase
    bad = (e_rd | e_wr) && (e_addr > 64'(MEM - 8));
    nerr = int'(merr | bad) + int'(ierr || icode > 4'hB) + int'(icode == 4'h0);
    if (merr || bad) e_st = 3'd3;
    else if (ierr || icode > 4'hB) e_st = 3'd4;
    else if (icode == 4'h0) e_st = 3'd2;
    else e_st = 3'd1;
    ok = (e_st == 3'd1);
    #(CLK_PERIOD/4);
    check(nerr > 1 ? "R9 stat" : "R8 stat", 64'(stat), 64'(e_st));
    check(ok ? {op_tag(icode), " enables"} : "R10 enables",
          {60'd0, pc_we, sp_we, mrd, mwr}, {60'd0, ok, ok & e_spc, ok & e_rd, ok & e_wr});
    if (ok) begin
      check({op_tag(icode), " next_pc"}, next_pc, e_pc);
      if (e_spc) check({op_tag(icode), " new_sp"}, new_sp, e_sp);
      if (e_rd | e_wr) check({op_tag(icode), " addr"}, maddr, e_addr);
      if (e_wr) check({op_tag(icode), " wdata"}, mwdata, e_wd);
    end
  endtask

  initial begin
    icode = 0; cond = 0; ierr = 0; merr = 0;
    valc = VALC; valp = VALP; sp = 64'd64; base = 0; srca = SRCA; rdata = RDAT;
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
    // reset-state inputs: halt, no enables
    check("R10 reset enables", {60'd0, pc_we, sp_we, mrd, mwr}, 64'd0);
    check("R8 reset stat", 64'(stat), 64'd2);
    for (int ic = 0; ic < 16; ic++)
      for (int c = 0; c < 2; c++)
        for (int e = 0; e < 4; e++)
          for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            icode = 4'(ic); cond = c[0]; ierr = e[0]; merr = e[1];
            case (k)
              0: begin sp = 64'd64;        base = 64'd16;        valc = 64'd8; end
              1: begin sp = 64'(MEM - 8);  base = 64'(MEM - 16); valc = 64'd8; end
              2: begin sp = 64'(MEM);      base = 64'(MEM - 16); valc = 64'd9; end
              3: begin sp = 64'd8;         base = 64'd0;         valc = 64'd0; end
              default: begin sp = 64'd0;   base = 64'd0;         valc = -64'sd8; end
            endcase
            run_one();
          end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule